// File: doc/BRIEF.md
# Strobed Byte FIFO Host Controller

This block lets a synchronous core move bytes to and from an external byte-wide FIFO device whose handshake is purely strobe-based. The device reports whether it holds a byte for the host (active-low "receive ready" flag) and whether it can take a byte from the host (active-low "transmit space" flag). The host fetches a byte with an active-low read strobe and hands over a byte with an active-high write strobe whose falling edge latches the data. One shared data bus carries traffic in both directions. The block brings it out as separate input, output and output-enable signals, so that a pad cell can build the tri-state buffer.

On the core side there is a receive stream, a one-cycle valid pulse with a data byte, and a transmit stream with a valid/ready handshake. Both device flags pass through a synchronizer chain before any decision is made. Each strobe is followed by a fixed recovery wait, which gives the synchronized flags time to reflect the device's new state. The strobe widths and the recovery time are parameters counted in clock cycles. When both directions can proceed, the controller alternates between them.

Top module: `pfifo_host`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises: rd_no=1, wr_o=0, dq_oe_o=0, rx_valid_o=0.
- R2: No read strobe starts while rxf_ni (1 = device empty) has been high for longer than the synchronizer depth. Each rd_no low pulse consumes exactly one device byte.
- R3: rd_no stays low for exactly RD_LOW_CYC cycles. The byte on dq_i at the clock edge that releases rd_no appears on rx_data_o, with rx_valid_o high for one cycle in the first cycle rd_no is high again.
- R4: While txe_ni (1 = device full) has been high for longer than the synchronizer depth, tx_ready_o stays low and no write strobe starts.
- R5: A byte accepted on tx_valid_i && tx_ready_o is driven on dq_o with dq_oe_o=1 and wr_o=1 for exactly WR_SETUP_CYC cycles. dq_o holds stable throughout.
- R6: In the cycle after wr_o falls, dq_oe_o stays 1 with dq_o unchanged. In the next cycle dq_oe_o is 0.
- R7: dq_oe_o is 0 whenever rd_no is low and in the cycle before rd_no falls.
- R8: The two strobes are never active together. Between the end of one strobe and the start of the next there are at least REC_CYC cycles with both strobes idle.
- R9: When reads and writes are both possible, the strobes alternate. After reset, a read wins the first tie.
- R10: Received and transmitted bytes keep their order, with no loss or duplication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rxf_ni | input | 1 | Device has a byte for the host when low (asynchronous) |
| txe_ni | input | 1 | Device can accept a byte when low (asynchronous) |
| rd_no | output | 1 | Read strobe, active low |
| wr_o | output | 1 | Write strobe, device latches on its falling edge |
| dq_i | input | DATA_W | Bus value seen at the pad |
| dq_o | output | DATA_W | Byte driven toward the pad |
| dq_oe_o | output | 1 | Pad output enable for dq_o |
| rx_valid_o | output | 1 | One-cycle pulse, rx_data_o holds a received byte |
| rx_data_o | output | DATA_W | Received byte |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Transmit byte accepted when both high |
| tx_data_i | input | DATA_W | Transmit byte |

## Verification
A sequencer stuck in the wrong state shows up at the pins within one strobe width. The symptoms are a strobe of the wrong length, bus drive that overlaps a read, or a write strobe whose data changes before the falling edge. A bad recovery count shrinks the idle gap on the very next transaction. A priority register that fails to flip breaks the read/write alternation within two transactions of a tie. A corrupted capture or acceptance path shows up as a byte mismatch at the device model or the receive stream on the first affected transfer.

// File: rtl/pfifo_host_pkg.sv
package pfifo_host_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LOW,
    ST_WR_SETUP,
    ST_WR_HOLD,
    ST_RECOVER
  } xfer_st_e;
endpackage

// File: rtl/pfifo_flag_sync.sv
module pfifo_flag_sync #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pfifo_dir_arb.sv
module pfifo_dir_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic idle_i,
  input  logic rd_req_i,
  input  logic wr_space_i,
  input  logic tx_valid_i,
  output logic tx_ready_o,
  output logic grant_rd_o,
  output logic grant_wr_o
);
  logic prio_wr_q;

  // ready never depends on tx_valid_i
  assign tx_ready_o = idle_i && wr_space_i && !(rd_req_i && !prio_wr_q);
  assign grant_wr_o = tx_ready_o && tx_valid_i;
  assign grant_rd_o = idle_i && rd_req_i && !grant_wr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         prio_wr_q <= 1'b0;
    else if (grant_rd_o) prio_wr_q <= 1'b1;
    else if (grant_wr_o) prio_wr_q <= 1'b0;
  end
endmodule

// File: rtl/pfifo_host.sv
module pfifo_host
  import pfifo_host_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned RD_LOW_CYC   = 4,
  parameter int unsigned WR_SETUP_CYC = 4,
  parameter int unsigned REC_CYC      = 4,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxf_ni,
  input  logic              txe_ni,
  output logic              rd_no,
  output logic              wr_o,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [DATA_W-1:0] tx_data_i
);
  localparam int unsigned MAX_A   = (RD_LOW_CYC > WR_SETUP_CYC) ? RD_LOW_CYC : WR_SETUP_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > REC_CYC) ? MAX_A : REC_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST  = CNT_W'(WR_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST = CNT_W'(REC_CYC - 1);

  xfer_st_e          st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              rd_n_q, wr_q, oe_q, rx_vld_q;
  logic [DATA_W-1:0] dq_q, rx_q;
  logic [1:0]        flags_s;
  logic              grant_rd, grant_wr;

  // flags_s[0]: receive flag, flags_s[1]: transmit flag
  pfifo_flag_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) flag_sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({txe_ni, rxf_ni}),
    .q_o   (flags_s)
  );

  pfifo_dir_arb arb_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idle_i    (st_q == ST_IDLE),
    .rd_req_i  (!flags_s[0]),
    .wr_space_i(!flags_s[1]),
    .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o),
    .grant_rd_o(grant_rd),
    .grant_wr_o(grant_wr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      rd_n_q   <= 1'b1;
      wr_q     <= 1'b0;
      oe_q     <= 1'b0;
      dq_q     <= '0;
      rx_q     <= '0;
      rx_vld_q <= 1'b0;
    end else begin
      rx_vld_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (grant_wr) begin
            wr_q <= 1'b1;
            oe_q <= 1'b1;
            dq_q <= tx_data_i;
            st_q <= ST_WR_SETUP;
          end else if (grant_rd) begin
            rd_n_q <= 1'b0;
            st_q   <= ST_RD_LOW;
          end
        end
        ST_RD_LOW: begin
          if (cnt_q == RD_LAST) begin
            rd_n_q   <= 1'b1;
            rx_q     <= dq_i;  // last clock with strobe low
            rx_vld_q <= 1'b1;
            cnt_q    <= '0;
            st_q     <= ST_RECOVER;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WR_SETUP: begin
          if (cnt_q == WR_LAST) begin
            wr_q  <= 1'b0;
            cnt_q <= '0;
            st_q  <= ST_WR_HOLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WR_HOLD: begin
          oe_q  <= 1'b0;
          cnt_q <= '0;
          st_q  <= ST_RECOVER;
        end
        ST_RECOVER: begin
          if (cnt_q == REC_LAST) begin
            cnt_q <= '0;
            st_q  <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_no      = rd_n_q;
  assign wr_o       = wr_q;
  assign dq_o       = dq_q;
  assign dq_oe_o    = oe_q;
  assign rx_valid_o = rx_vld_q;
  assign rx_data_o  = rx_q;
endmodule

// File: rtl/pfifo_host_chk.sv
module pfifo_host_chk #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned RD_LOW_CYC   = 4,
  parameter int unsigned WR_SETUP_CYC = 4,
  parameter int unsigned REC_CYC      = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_no,
  input logic              wr_o,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o,
  input logic              rx_valid_o
);
  logic [15:0] rd_lo_cnt, wr_hi_cnt, idle_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_lo_cnt <= '0;
      wr_hi_cnt <= '0;
      idle_cnt  <= '1;
    end else begin
      rd_lo_cnt <= rd_no ? '0 : rd_lo_cnt + 1'b1;
      wr_hi_cnt <= wr_o ? wr_hi_cnt + 1'b1 : '0;
      if (!rd_no || wr_o)    idle_cnt <= '0;
      else if (~&idle_cnt)   idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // R7
  rd_bus_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !dq_oe_o);
  // R7
  rd_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no) |-> !$past(dq_oe_o));
  // R3
  rd_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_no) |-> rd_lo_cnt == 16'(RD_LOW_CYC));
  // R3
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $rose(rd_no));
  // R5
  wr_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_o) |-> wr_hi_cnt == 16'(WR_SETUP_CYC));
  // R5
  wr_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_o && $past(wr_o)) |-> ($stable(dq_o) && dq_oe_o));
  // R6
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_o) |-> (dq_oe_o && $stable(dq_o)));
  // R6
  wr_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_o) |=> !dq_oe_o);
  // R8
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && wr_o));
  // R8
  recover_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rd_no) || $rose(wr_o)) |-> idle_cnt >= 16'(REC_CYC));
endmodule

bind pfifo_host pfifo_host_chk #(
  .DATA_W      (DATA_W),
  .RD_LOW_CYC  (RD_LOW_CYC),
  .WR_SETUP_CYC(WR_SETUP_CYC),
  .REC_CYC     (REC_CYC)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_no     (rd_no),
  .wr_o      (wr_o),
  .dq_o      (dq_o),
  .dq_oe_o   (dq_oe_o),
  .rx_valid_o(rx_valid_o)
);

// File: tb/pfifo_host_tb_top.sv
module pfifo_host_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 8;
  localparam int RDL = 4;
  localparam int WRS = 4;
  localparam int REC = 4;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic rxf_n = 1'b1;
  logic dev_block;
  logic rd_no, wr_o, dq_oe_o, rx_valid_o, tx_ready_o;
  logic tx_valid_i = 1'b0;
  logic [DW-1:0] tx_data_i = '0;
  logic [DW-1:0] dq_i, dq_o, rx_data_o;
  logic [DW-1:0] dev_cur = '0;

  int total = 0, bad = 0;
  logic [DW-1:0] dev_q[$], exp_rx[$], exp_tx[$];
  int  kind_log[64];
  int  kind_n = 0, n_strobe = 0;
  bit  tx_en = 0, fire_q = 0;
  int  tx_left = 0, tx_gap_pct = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  assign dq_i = rd_no ? 8'h5A : dev_cur;

  pfifo_host #(.DATA_W(DW), .RD_LOW_CYC(RDL), .WR_SETUP_CYC(WRS), .REC_CYC(REC)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxf_ni(rxf_n), .txe_ni(dev_block),
    .rd_no(rd_no), .wr_o(wr_o), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o), .tx_data_i(tx_data_i));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // R9: tie sequence starts with read, then alternates (0=read, 1=write)
  function automatic int exp_kind(input int i);
    return i % 2;
  endfunction

  function automatic logic [DW-1:0] mk_byte(input int i);
    return DW'((i * 37 + 11) ^ $urandom);
  endfunction

  task automatic dev_push(input logic [DW-1:0] b);
    dev_q.push_back(b);
    exp_rx.push_back(b);
    rxf_n = 1'b0;
  endtask

  // device read side: next byte fetched on falling read strobe (R2)
  always @(negedge rd_no) begin
    if (rst_ni) begin
      chk(dev_q.size() != 0, "R2 read from empty device", 0, 1);
      if (dev_q.size() != 0) dev_cur = dev_q.pop_front();
      if (dev_q.size() == 0) rxf_n = 1'b1;
    end
  end

  // device write side: latch on falling write strobe (R5 R10)
  always @(negedge wr_o) begin
    if (rst_ni) begin
      chk(dq_oe_o, "R5 bus not driven at latch", dq_oe_o, 1);
      if (exp_tx.size() == 0) chk(0, "R10 unexpected write", dq_o, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_tx.pop_front();
        chk(dq_o == e, "R10 tx byte", dq_o, e);
      end
    end
  end

  // receive stream (R3 R10)
  always @(negedge clk_i) begin
    if (rst_ni && rx_valid_o) begin
      if (exp_rx.size() == 0) chk(0, "R10 unexpected rx", rx_data_o, 0);
      else begin
        logic [DW-1:0] e;
        e = exp_rx.pop_front();
        chk(rx_data_o == e, "R3 rx byte", rx_data_o, e);
      end
    end
  end

  // transmit stream driver
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      tx_valid_i = 1'b0;
      fire_q = 0;
    end else begin
      if (fire_q || !tx_valid_i) begin
        if (tx_en && tx_left > 0 && int'($urandom % 100) >= tx_gap_pct) begin
          tx_valid_i = 1'b1;
          tx_data_i = mk_byte(tx_left);
          tx_left--;
        end else tx_valid_i = 1'b0;
      end
      fire_q = tx_valid_i && tx_ready_o;
      if (fire_q) exp_tx.push_back(tx_data_i);
    end
  end

  // pin timing monitor
  logic prev_rd = 1'b1, prev_wr = 1'b0, prev_oe = 1'b0, hold_nx = 1'b0;
  logic [DW-1:0] prev_dq = '0;
  int rd_w = 0, wr_w = 0, idle_w = 1000;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!rd_no) chk(!dq_oe_o, "R7 bus driven during read", dq_oe_o, 0);
      if (hold_nx) begin
        chk(!dq_oe_o, "R6 bus not released", dq_oe_o, 0);
        hold_nx = 0;
      end
      if (prev_rd && !rd_no) begin
        chk(!prev_oe, "R7 no turnaround", prev_oe, 0);
        chk(idle_w >= REC, "R8 gap before read", idle_w, REC);
        chk(wr_o == 0, "R8 strobe overlap", wr_o, 0);
        if (kind_n < 64) kind_log[kind_n] = 0;
        kind_n++; n_strobe++;
        rd_w = 1;
      end else if (!rd_no) rd_w++;
      if (!prev_rd && rd_no) chk(rd_w == RDL, "R3 read width", rd_w, RDL);
      if (!prev_wr && wr_o) begin
        chk(idle_w >= REC, "R8 gap before write", idle_w, REC);
        if (kind_n < 64) kind_log[kind_n] = 1;
        kind_n++; n_strobe++;
        wr_w = 1;
      end else if (wr_o) begin
        wr_w++;
        chk(dq_oe_o && dq_o == prev_dq, "R5 data unstable", dq_o, prev_dq);
      end
      if (prev_wr && !wr_o) begin
        chk(wr_w == WRS, "R5 write width", wr_w, WRS);
        chk(dq_oe_o && dq_o == prev_dq, "R6 hold cycle", dq_o, prev_dq);
        hold_nx = 1;
      end
      if (rd_no && !wr_o) idle_w++; else idle_w = 0;
    end
    prev_rd = rd_no; prev_wr = wr_o; prev_oe = dq_oe_o; prev_dq = dq_o;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n0, w;
    void'($urandom(32'h1F2E3D4C));
    rst_ni = 1'b0;
    dev_block = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(rd_no && !wr_o && !dq_oe_o && !rx_valid_o, "R1 in reset",
        {rd_no, wr_o, dq_oe_o, rx_valid_o}, 4'b1000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(rd_no && !wr_o && !dq_oe_o && !rx_valid_o, "R1 after reset",
        {rd_no, wr_o, dq_oe_o, rx_valid_o}, 4'b1000);

    // device empty and full: nothing moves
    #1; tx_en = 1; tx_left = 1; tx_gap_pct = 0;
    n0 = n_strobe;
    repeat (40) begin
      @(negedge clk_i);
      chk(!tx_ready_o, "R4 ready while full", tx_ready_o, 0);
    end
    chk(n_strobe == n0, "R2 R4 strobe while blocked", n_strobe, n0);

    // tie: both directions ready continuously
    #1;
    kind_n = 0;
    for (int i = 0; i < 6; i++) dev_push(mk_byte(i + 100));
    tx_left = 5;
    dev_block = 1'b0;
    w = 0;
    while (kind_n < 12 && w < 2000) begin @(negedge clk_i); w++; end
    for (int i = 0; i < 12; i++)
      chk(kind_log[i] == exp_kind(i), "R9 alternation", kind_log[i], exp_kind(i));

    // random traffic
    #1; tx_left = 100000;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk_i); #1;
      if (c % 200 == 0) tx_gap_pct = int'($urandom % 80);
      if (c % 50 == 0) dev_block = ($urandom % 100) < 30;
      if (dev_q.size() < 8 && ($urandom % 100) < 15) dev_push(mk_byte(c));
    end

    // drain
    tx_en = 0; dev_block = 1'b0;
    w = 0;
    while ((exp_rx.size() != 0 || exp_tx.size() != 0 || tx_valid_i) && w < 3000) begin
      @(negedge clk_i); w++;
    end
    repeat (20) @(negedge clk_i);
    chk(exp_rx.size() == 0, "R10 rx bytes lost", exp_rx.size(), 0);
    chk(exp_tx.size() == 0, "R10 tx bytes lost", exp_tx.size(), 0);
    chk(rd_no && !wr_o && !dq_oe_o, "R8 idle at end", {rd_no, wr_o, dq_oe_o}, 3'b100);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule